// File: doc/BRIEF.md
# Bit-Serial Display Command Transmitter

This block sends bytes to a monochrome LCD controller over a write-only serial link. The link has a clock, a data line, an active-low chip select and a register-select line that tells the panel whether a byte is a command or pixel data. A producer offers one byte at a time on a valid/ready handshake. Two side flags come with each byte: one marks it as data or command, the other says that another byte of the same burst follows.

Every bit is sent in three timed phases. The clock is held low, then the data bit is presented with the clock still low, then the clock is raised. Each phase lasts a parameterised number of system clocks. A byte sent on its own is followed by a gap before chip select is released. Bytes inside a burst follow each other with no gap, and one gap of its own length follows the last byte of the burst. Raising the register-select line and releasing chip select are each followed by a settle wait. Lowering the register-select line and asserting chip select have no wait.

The state machine has seven states:
- ST_IDLE: waiting for a byte.
- ST_A0_WAIT: register-select settle.
- ST_CLK_LO: clock-low phase.
- ST_DAT: data phase.
- ST_CLK_HI: clock-high phase.
- ST_GAP: gap after a byte or a burst.
- ST_CS_WAIT: chip-select release settle.

Its transitions are:
- accept: ST_IDLE to ST_A0_WAIT when the register-select line must rise, otherwise ST_IDLE to ST_CLK_LO.
- settle-done: ST_A0_WAIT to ST_CLK_LO.
- present: ST_CLK_LO to ST_DAT.
- rise: ST_DAT to ST_CLK_HI.
- next-bit: ST_CLK_HI to ST_CLK_LO.
- burst-continue: ST_CLK_HI to ST_IDLE after the eighth bit when more bytes follow.
- byte-end: ST_CLK_HI to ST_GAP after the eighth bit when no more bytes follow.
- release: ST_GAP to ST_CS_WAIT.
- ready: ST_CS_WAIT to ST_IDLE.

Top module: `lcd_serial_tx`

## Requirements
- R1: The eight bits of a byte appear on `lcd_sdo` from bit 7 down to bit 0. Each bit is presented at the start of its data phase and holds through its clock-high phase.
- R2: Each bit has three phases in this order. A clock-low phase lasts DLY_LO+1 cycles, a data phase lasts DLY_DAT+1 cycles with the clock still low, and a clock-high phase lasts DLY_HI+1 cycles. A delay of zero leaves a phase of one cycle.
- R3: Exactly eight clock-high pulses are produced per byte. `lcd_sclk` is low at all other times and only rises while `lcd_cs_n` is low.
- R4: A byte with `in_more`=0 that does not end a burst is followed by GAP_BYTE+1 cycles with chip select still low. Chip select is then released.
- R5: A byte with `in_more`=1 returns `in_ready` high in the cycle after its last clock-high phase, with no gap and with chip select kept low. The byte that ends the burst (`in_more`=0 after a byte with `in_more`=1) is followed by GAP_BURST+1 cycles before release.
- R6: `lcd_a0` takes the value of `in_is_data` (1 = data, 0 = command). When it rises, SETTLE+1 cycles pass before the first clock-low phase. When it falls or keeps its value, the first clock-low phase starts at once.
- R7: `lcd_cs_n` goes low in the cycle after acceptance with no wait. After the final gap it is driven high for SETTLE+1 cycles before `in_ready` returns.
- R8: `in_ready` is low from the cycle after acceptance until the end of the chip-select settle, or until the end of a burst byte. A byte is taken only when `in_valid` and `in_ready` are both high. `in_valid` while `in_ready` is low changes no output.
- R9: During reset, `lcd_sclk`, `lcd_sdo` and `lcd_a0` are low, `lcd_cs_n` is high and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_more | input | 1 | Another byte of the same burst follows |
| lcd_sclk | output | 1 | Serial clock, idles low |
| lcd_sdo | output | 1 | Serial data |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_a0 | output | 1 | Register select, high for data |

## Verification
The main function is tried with the following patterns:
- Alternating bit patterns, all-ones and all-zeros bytes, and single-bit bytes. These separate bit order from shift direction and show stuck data.
- Commands after data, data after commands, and data after data. These tell the rising register-select wait apart from the no-wait cases.
- Single bytes, two- and three-byte bursts, and a single byte right after a burst. These tell the per-byte gap apart from the burst gap and from the no-gap case.
- Offers made in the very cycle that ready returns, and junk offers while busy. These show that acceptance is exact and that busy-time offers have no effect.

// File: rtl/lcd_tx_pkg.sv
package lcd_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A0_WAIT,
        ST_CLK_LO,
        ST_DAT,
        ST_CLK_HI,
        ST_GAP,
        ST_CS_WAIT
    } tx_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_tx_timer.sv
module lcd_tx_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_tx_shifter.sv
module lcd_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign msb  = sh_q[W-1];
    assign last = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx
    import lcd_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DLY_LO    = 0,
    parameter int DLY_DAT   = 0,
    parameter int DLY_HI    = 1,
    parameter int GAP_BYTE  = 1250,
    parameter int GAP_BURST = 1250,
    parameter int SETTLE    = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_is_data,
    input  logic              in_more,
    output logic              lcd_sclk,
    output logic              lcd_sdo,
    output logic              lcd_cs_n,
    output logic              lcd_a0
);
    localparam int MAX_DLY = max_of(max_of(max_of(DLY_LO, DLY_DAT), max_of(DLY_HI, SETTLE)),
                                    max_of(GAP_BYTE, GAP_BURST));
    localparam int TW = $clog2(MAX_DLY + 1) + 1;
    localparam logic [TW-1:0] T_LO    = TW'(DLY_LO);
    localparam logic [TW-1:0] T_DAT   = TW'(DLY_DAT);
    localparam logic [TW-1:0] T_HI    = TW'(DLY_HI);
    localparam logic [TW-1:0] T_GBYTE = TW'(GAP_BYTE);
    localparam logic [TW-1:0] T_GBRST = TW'(GAP_BURST);
    localparam logic [TW-1:0] T_SET   = TW'(SETTLE);

    tx_state_e     state_q, state_d;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_msb, sh_last;
    logic          more_q, burst_q;
    logic          accept;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    lcd_tx_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    lcd_tx_shifter #(.W(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .din   (in_byte),
        .shift (sh_shift),
        .msb   (sh_msb),
        .last  (sh_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and timer/shifter control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    if (in_is_data && !lcd_a0) begin
                        state_d = ST_A0_WAIT;
                        tmr_val = T_SET;
                    end else begin
                        state_d = ST_CLK_LO;
                        tmr_val = T_LO;
                    end
                end
            end
            ST_A0_WAIT: if (tmr_exp) begin
                state_d  = ST_CLK_LO;
                tmr_load = 1'b1;
                tmr_val  = T_LO;
            end
            ST_CLK_LO: if (tmr_exp) begin
                state_d  = ST_DAT;
                tmr_load = 1'b1;
                tmr_val  = T_DAT;
            end
            ST_DAT: if (tmr_exp) begin
                state_d  = ST_CLK_HI;
                tmr_load = 1'b1;
                tmr_val  = T_HI;
            end
            ST_CLK_HI: if (tmr_exp) begin
                sh_shift = 1'b1;
                tmr_load = 1'b1;
                if (!sh_last) begin
                    state_d = ST_CLK_LO;
                    tmr_val = T_LO;
                end else if (more_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_GAP;
                    tmr_val = burst_q ? T_GBRST : T_GBYTE;
                end
            end
            ST_GAP: if (tmr_exp) begin
                state_d  = ST_CS_WAIT;
                tmr_load = 1'b1;
                tmr_val  = T_SET;
            end
            ST_CS_WAIT: if (tmr_exp) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // serial pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcd_sclk <= 1'b0;
            lcd_sdo  <= 1'b0;
            lcd_cs_n <= 1'b1;
            lcd_a0   <= 1'b0;
            more_q   <= 1'b0;
            burst_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    lcd_cs_n <= 1'b0;
                    lcd_a0   <= in_is_data;
                    more_q   <= in_more;
                end
                ST_CLK_LO:  if (tmr_exp) lcd_sdo <= sh_msb;
                ST_DAT:     if (tmr_exp) lcd_sclk <= 1'b1;
                ST_CLK_HI: if (tmr_exp) begin
                    lcd_sclk <= 1'b0;
                    if (sh_last) burst_q <= more_q;
                end
                ST_GAP:     if (tmr_exp) lcd_cs_n <= 1'b1;
                ST_A0_WAIT, ST_CS_WAIT: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcd_serial_tx_chk.sv
module lcd_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic lcd_sclk,
    input logic lcd_sdo,
    input logic lcd_cs_n,
    input logic lcd_a0
);
    AST_SDO_HELD_CLK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sclk |-> $stable(lcd_sdo)); // R1
    AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sclk |-> !lcd_cs_n); // R3
    AST_A0_HELD_CLK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sclk |-> $stable(lcd_a0)); // R6
    AST_CS_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> !in_ready); // R7
    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !lcd_cs_n)); // R8
    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !lcd_sclk); // R8
endmodule

bind lcd_serial_tx lcd_serial_tx_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .lcd_sclk (lcd_sclk),
    .lcd_sdo  (lcd_sdo),
    .lcd_cs_n (lcd_cs_n),
    .lcd_a0   (lcd_a0)
);

// File: tb/lcd_serial_tx_tb_top.sv
module lcd_serial_tx_tb_top;
    localparam int P_LO = 1, P_DAT = 0, P_HI = 2, P_GB = 3, P_GR = 5, P_SET = 2;
    localparam int N_ITEMS = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_is_data, in_more;
    logic [7:0] in_byte;
    logic       lcd_sclk, lcd_sdo, lcd_cs_n, lcd_a0;

    always #4 clk = ~clk;

    lcd_serial_tx #(
        .BYTE_W(8), .DLY_LO(P_LO), .DLY_DAT(P_DAT), .DLY_HI(P_HI),
        .GAP_BYTE(P_GB), .GAP_BURST(P_GR), .SETTLE(P_SET)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data), .in_more(in_more),
        .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo), .lcd_cs_n(lcd_cs_n), .lcd_a0(lcd_a0)
    );

    int checks = 0;
    int fails  = 0;

    // expected tuple {cs_n, a0, sclk, sdo, ready}
    logic [4:0] q[$];
    logic       m_cs = 1'b1, m_a0 = 1'b0, m_sdo = 1'b0, m_burst = 1'b0;

    logic [7:0] st_b[N_ITEMS];
    logic       st_d[N_ITEMS];
    logic       st_m[N_ITEMS];
    int         st_w[N_ITEMS];

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic push_n(input int n, input logic cs, input logic a0, input logic sc,
                          input logic sd, input logic rd);
        for (int k = 0; k < n; k++) q.push_back({cs, a0, sc, sd, rd});
    endtask

    task automatic build(input logic [7:0] b, input logic d, input logic more);
        m_cs = 1'b0;
        if (d && !m_a0) push_n(P_SET + 1, 1'b0, 1'b1, 1'b0, m_sdo, 1'b0); // R6 rise wait
        m_a0 = d;
        for (int i = 7; i >= 0; i--) begin
            push_n(P_LO + 1, 1'b0, m_a0, 1'b0, m_sdo, 1'b0);
            m_sdo = b[i];                                                  // R1 msb first
            push_n(P_DAT + 1, 1'b0, m_a0, 1'b0, m_sdo, 1'b0);
            push_n(P_HI + 1, 1'b0, m_a0, 1'b1, m_sdo, 1'b0);
        end
        if (!more) begin
            push_n((m_burst ? P_GR : P_GB) + 1, 1'b0, m_a0, 1'b0, m_sdo, 1'b0); // R4 R5
            push_n(P_SET + 1, 1'b1, m_a0, 1'b0, m_sdo, 1'b0);                   // R7
            m_cs    = 1'b1;
            m_burst = 1'b0;
        end else begin
            m_burst = 1'b1;
        end
    endtask

    initial begin
        logic [4:0]  exp;
        logic [15:0] lfsr;
        int          si, wcnt, tail, cyc;

        // byte, is_data, more, idle cycles before offer
        st_b[0]  = 8'hA5; st_d[0]  = 0; st_m[0]  = 0; st_w[0]  = 0; // single command
        st_b[1]  = 8'h3C; st_d[1]  = 1; st_m[1]  = 0; st_w[1]  = 2; // data, A0 rises
        st_b[2]  = 8'h81; st_d[2]  = 1; st_m[2]  = 0; st_w[2]  = 0; // data, A0 already high
        st_b[3]  = 8'h0F; st_d[3]  = 0; st_m[3]  = 0; st_w[3]  = 1; // command, A0 falls
        st_b[4]  = 8'hFF; st_d[4]  = 1; st_m[4]  = 1; st_w[4]  = 0; // burst start
        st_b[5]  = 8'h00; st_d[5]  = 1; st_m[5]  = 1; st_w[5]  = 0;
        st_b[6]  = 8'h5A; st_d[6]  = 1; st_m[6]  = 0; st_w[6]  = 3; // burst end
        st_b[7]  = 8'h80; st_d[7]  = 0; st_m[7]  = 0; st_w[7]  = 0; // single after burst
        st_b[8]  = 8'h01; st_d[8]  = 0; st_m[8]  = 1; st_w[8]  = 0; // command burst
        st_b[9]  = 8'hFE; st_d[9]  = 0; st_m[9]  = 0; st_w[9]  = 0;
        st_b[10] = 8'h7E; st_d[10] = 1; st_m[10] = 0; st_w[10] = 1;
        st_b[11] = 8'h96; st_d[11] = 0; st_m[11] = 0; st_w[11] = 0;

        rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_is_data = 1'b0; in_more = 1'b0;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        chk("R9", "sclk",  lcd_sclk, 1'b0);
        chk("R9", "sdo",   lcd_sdo,  1'b0);
        chk("R9", "a0",    lcd_a0,   1'b0);
        chk("R9", "cs_n",  lcd_cs_n, 1'b1);
        chk("R9", "ready", in_ready, 1'b1);
        rst_n = 1'b1;

        exp = 5'b10001;
        si = 0; wcnt = 0; tail = 0; cyc = 0;
        while (tail < 6 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            chk("R7 R4 R5",  "cs_n",  lcd_cs_n, exp[4]);
            chk("R6",        "a0",    lcd_a0,   exp[3]);
            chk("R2 R3",     "sclk",  lcd_sclk, exp[2]);
            chk("R1",        "sdo",   lcd_sdo,  exp[1]);
            chk("R8 R5",     "ready", in_ready, exp[0]);
            in_valid = 1'b0;
            if (exp[0] && si < N_ITEMS) begin
                if (wcnt < st_w[si]) begin
                    wcnt++;
                end else begin
                    in_valid = 1'b1; in_byte = st_b[si];
                    in_is_data = st_d[si]; in_more = st_m[si];
                    build(st_b[si], st_d[si], st_m[si]);
                    si++; wcnt = 0;
                end
            end else if (!exp[0]) begin
                // R8: offers while busy must be ignored
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                in_valid = lfsr[0]; in_byte = lfsr[8:1];
                in_is_data = lfsr[9]; in_more = lfsr[10];
            end
            exp = (q.size() > 0) ? q.pop_front() : {m_cs, m_a0, 1'b0, m_sdo, 1'b1};
            if (si == N_ITEMS && q.size() == 0) tail++;
        end
        if (cyc >= 20000) begin
            checks++; fails++;
            $display("FAIL R8 watchdog actual=%0d expected<%0d", cyc, 20000);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule